// File: doc/BRIEF.md
# Converter Interrupt Vector Generator

This block gathers the interrupt conditions of a conversion-result memory with a parameterised number of slots (sixteen by default). It keeps one "result ready" flag per slot. It also watches for two error conditions that have no visible flag: a slot result that is overwritten before anyone read it, and a sample request that arrives while a conversion is still running. All pending sources are ranked and encoded into one even vector code. Software can use that code directly as a jump-table offset.

A CPU-side decoder pulses `vec_acc` whenever the vector register is read or written. That access retires an error condition, but only when the registered vector shows that condition's code at that moment. Slot flags are never touched by the access. They clear when their slot is read or when software clears them. `irq` stays high for as long as any enabled source is pending and the global enable is set. Every pin is a plain control or status signal. No stream interface exists, so no back-pressure rules apply.

Top module: `cvt_irq_vec`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `vec_out` is 0 and `irq` is 0. All flags and error conditions are clear.
- R2: A pulse on `slot_wr[n]` sets the flag of slot n. When slot n is the top-ranked enabled pending source, `vec_out` equals 6 + 2·n.
- R3: `irq` is 1 exactly when `glb_en` is 1 and at least one source is both pending and enabled.
- R4: The overwrite condition is raised when `slot_wr[n]` hits a slot whose last result has not been read. A `slot_rd[n]` in the same cycle counts as reading the old result. Its code is 2.
- R5: The overrun condition is raised when `conv_req` and `conv_busy` are both 1 in the same cycle. Its code is 4.
- R6: `src_en` selects which sources take part: bit 0 is overwrite, bit 1 is overrun, and bit 2+n is slot n. The ranking from highest to lowest is overwrite, overrun, slot 0 up to slot 15. Disabled sources never change `vec_out`. When nothing enabled is pending, `vec_out` is 0.
- R7: A `vec_acc` pulse clears the overwrite condition only when `vec_out` is 2 in that cycle. It clears the overrun condition only when `vec_out` is 4.
- R8: A `vec_acc` pulse never clears a slot flag. A slot flag is cleared by `slot_rd[n]` or `slot_clr[n]`.
- R9: When a set and a clear reach the same flag or condition in the same cycle, the set wins.
- R10: After one source is retired, `irq` stays 1 while another enabled source is still pending.
- R11: `vec_out` and `irq` are registered. They show the state that results from the inputs sampled at the same clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_wr | input | NUM_SLOTS | Per-slot pulse: a new result was written into the slot |
| slot_rd | input | NUM_SLOTS | Per-slot pulse: the slot was read |
| slot_clr | input | NUM_SLOTS | Per-slot software clear of the ready flag |
| conv_req | input | 1 | A sample-and-convert request |
| conv_busy | input | 1 | A conversion is in progress |
| src_en | input | NUM_SLOTS+2 | Per-source enable mask |
| glb_en | input | 1 | Global interrupt enable |
| vec_acc | input | 1 | Read or write of the vector register |
| vec_out | output | VEC_W | Registered vector code |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situations to reach are the ones where a vector access meets an error condition that is pending but not shown on `vec_out`. This happens when the condition is masked, is outranked, or was raised in the same cycle as the access. In each of these cases the condition must survive the access. The directed phase sets these up explicitly: it masks the overrun, accesses the vector while a slot code is shown, then unmasks the overrun and checks that it reappears before retiring it. The random phase then fires accesses, rewrites, reads and requests densely enough that these cases also occur many times at random.

// File: rtl/cvig_pkg.sv
package cvig_pkg;
  localparam int OVW_IDX   = 0;
  localparam int OVR_IDX   = 1;
  localparam int SLOT_BASE = 2;

  function automatic int code_of(int idx);
    return 2 * (idx + 1);
  endfunction
endpackage

// File: rtl/cvig_slot_flags.sv
module cvig_slot_flags #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] wr,
  input  logic [N-1:0] rd,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag_q,
  output logic [N-1:0] flag_nxt,
  output logic [N-1:0] unread_q,
  output logic         ovw_evt
);
  logic [N-1:0] unread_nxt;
  logic [N-1:0] ovw_hit;

  for (genvar g = 0; g < N; g++) begin : g_slot
    always_comb begin
      flag_nxt[g]   = wr[g] | (flag_q[g] & ~(rd[g] | clr[g]));
      unread_nxt[g] = wr[g] | (unread_q[g] & ~rd[g]);
      ovw_hit[g]    = wr[g] & unread_q[g] & ~rd[g];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flag_q[g]   <= 1'b0;
        unread_q[g] <= 1'b0;
      end else begin
        flag_q[g]   <= flag_nxt[g];
        unread_q[g] <= unread_nxt[g];
      end
    end
  end

  assign ovw_evt = |ovw_hit;
endmodule

// File: rtl/cvig_err_cond.sv
module cvig_err_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ovw,
  input  logic set_ovr,
  input  logic clr_ovw,
  input  logic clr_ovr,
  output logic ovw_q,
  output logic ovr_q,
  output logic ovw_nxt,
  output logic ovr_nxt
);
  always_comb begin
    ovw_nxt = set_ovw | (ovw_q & ~clr_ovw);
    ovr_nxt = set_ovr | (ovr_q & ~clr_ovr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovw_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      ovw_q <= ovw_nxt;
      ovr_q <= ovr_nxt;
    end
  end
endmodule

// File: rtl/cvig_prio_enc.sv
module cvig_prio_enc #(
  parameter int NSRC = 18,
  parameter int VW   = 6
) (
  input  logic [NSRC-1:0] pend,
  output logic [VW-1:0]   code
);
  import cvig_pkg::*;

  always_comb begin
    code = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i]) code = VW'(code_of(i));
    end
  end
endmodule

// File: rtl/cvt_irq_vec.sv
module cvt_irq_vec #(
  parameter  int NUM_SLOTS = 16,
  localparam int NUM_SRC   = NUM_SLOTS + 2,
  localparam int VEC_W     = $clog2(2 * NUM_SRC + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] slot_wr,
  input  logic [NUM_SLOTS-1:0] slot_rd,
  input  logic [NUM_SLOTS-1:0] slot_clr,
  input  logic                 conv_req,
  input  logic                 conv_busy,
  input  logic [NUM_SRC-1:0]   src_en,
  input  logic                 glb_en,
  input  logic                 vec_acc,
  output logic [VEC_W-1:0]     vec_out,
  output logic                 irq
);
  import cvig_pkg::*;

  localparam logic [VEC_W-1:0] OVW_CODE = VEC_W'(code_of(OVW_IDX));
  localparam logic [VEC_W-1:0] OVR_CODE = VEC_W'(code_of(OVR_IDX));

  logic [NUM_SLOTS-1:0] flag_q, flag_nxt, unread_q;
  logic                 ovw_evt, ovr_evt;
  logic                 ovw_q, ovr_q, ovw_nxt, ovr_nxt;
  logic                 clr_ovw, clr_ovr;
  logic [NUM_SRC-1:0]   pend_en;
  logic [VEC_W-1:0]     code_nxt;
  logic [VEC_W-1:0]     vec_q;
  logic                 irq_q;

  cvig_slot_flags #(.N(NUM_SLOTS)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (slot_wr),
    .rd       (slot_rd),
    .clr      (slot_clr),
    .flag_q   (flag_q),
    .flag_nxt (flag_nxt),
    .unread_q (unread_q),
    .ovw_evt  (ovw_evt)
  );

  assign ovr_evt = conv_req & conv_busy;
  assign clr_ovw = vec_acc & (vec_q == OVW_CODE);
  assign clr_ovr = vec_acc & (vec_q == OVR_CODE);

  cvig_err_cond u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_ovw (ovw_evt),
    .set_ovr (ovr_evt),
    .clr_ovw (clr_ovw),
    .clr_ovr (clr_ovr),
    .ovw_q   (ovw_q),
    .ovr_q   (ovr_q),
    .ovw_nxt (ovw_nxt),
    .ovr_nxt (ovr_nxt)
  );

  assign pend_en = {flag_nxt, ovr_nxt, ovw_nxt} & src_en;

  cvig_prio_enc #(.NSRC(NUM_SRC), .VW(VEC_W)) u_enc (
    .pend (pend_en),
    .code (code_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q <= '0;
      irq_q <= 1'b0;
    end else begin
      vec_q <= code_nxt;
      irq_q <= glb_en & (|pend_en);
    end
  end

  assign vec_out = vec_q;
  assign irq     = irq_q;
endmodule

// File: rtl/cvt_irq_vec_chk.sv
module cvt_irq_vec_chk #(
  parameter int NUM_SLOTS = 16,
  parameter int VEC_W     = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_SLOTS-1:0] slot_wr,
  input logic [NUM_SLOTS-1:0] slot_rd,
  input logic [NUM_SLOTS-1:0] slot_clr,
  input logic [NUM_SLOTS-1:0] unread_q,
  input logic [NUM_SLOTS-1:0] flag_q,
  input logic                 conv_req,
  input logic                 conv_busy,
  input logic                 glb_en,
  input logic                 vec_acc,
  input logic                 ovw_q,
  input logic                 ovr_q,
  input logic                 ovw_evt,
  input logic [VEC_W-1:0]     vec_out,
  input logic                 irq
);
  // R2
  slot_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|slot_wr) |=> ((flag_q & $past(slot_wr)) == $past(slot_wr)));

  // R3
  irq_glb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |=> !irq);

  // R4
  ovw_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(slot_wr & unread_q & ~slot_rd)) |=> ovw_q);

  // R5
  ovr_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && conv_busy) |=> ovr_q);

  // R6
  ovw_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_out == VEC_W'(2)) |-> ovw_q);

  // R7
  ovw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_acc && vec_out == VEC_W'(2) && !ovw_evt) |=> !ovw_q);

  // R7
  ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_acc && ovr_q && vec_out != VEC_W'(4)) |=> ovr_q);

  // R8
  acc_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_acc |=> ((flag_q & $past(flag_q & ~(slot_rd | slot_clr)))
                 == $past(flag_q & ~(slot_rd | slot_clr))));
endmodule

bind cvt_irq_vec cvt_irq_vec_chk #(.NUM_SLOTS(NUM_SLOTS), .VEC_W(VEC_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .slot_wr   (slot_wr),
  .slot_rd   (slot_rd),
  .slot_clr  (slot_clr),
  .unread_q  (unread_q),
  .flag_q    (flag_q),
  .conv_req  (conv_req),
  .conv_busy (conv_busy),
  .glb_en    (glb_en),
  .vec_acc   (vec_acc),
  .ovw_q     (ovw_q),
  .ovr_q     (ovr_q),
  .ovw_evt   (ovw_evt),
  .vec_out   (vec_out),
  .irq       (irq)
);

// File: tb/cvt_irq_vec_tb_top.sv
module cvt_irq_vec_tb_top;
  localparam int CLK_P = 10;
  localparam int NS    = 16;
  localparam int NSRC  = NS + 2;
  localparam int VW    = $clog2(2 * NSRC + 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NS-1:0]   slot_wr = '0, slot_rd = '0, slot_clr = '0;
  logic            conv_req = 1'b0, conv_busy = 1'b0;
  logic [NSRC-1:0] src_en = '0;
  logic            glb_en = 1'b0, vec_acc = 1'b0;
  logic [VW-1:0]   vec_out;
  logic            irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [NS-1:0] m_flag = '0, m_unr = '0;
  logic          m_ovw = 1'b0, m_ovr = 1'b0;
  logic [VW-1:0] m_vec = '0;
  logic          m_irq = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  cvt_irq_vec #(.NUM_SLOTS(NS)) dut_i (
    .clk(clk), .rst_n(rst_n), .slot_wr(slot_wr), .slot_rd(slot_rd),
    .slot_clr(slot_clr), .conv_req(conv_req), .conv_busy(conv_busy),
    .src_en(src_en), .glb_en(glb_en), .vec_acc(vec_acc),
    .vec_out(vec_out), .irq(irq)
  );

  function automatic logic [VW-1:0] enc(logic [NSRC-1:0] p);
    for (int i = 0; i < NSRC; i++) if (p[i]) return VW'(2 * (i + 1));
    return '0;
  endfunction

  task automatic chk(string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    logic [NS-1:0]   nf, nu;
    logic            no, nr;
    logic [NSRC-1:0] p;
    nf = slot_wr | (m_flag & ~(slot_rd | slot_clr));
    nu = slot_wr | (m_unr & ~slot_rd);
    no = (|(slot_wr & m_unr & ~slot_rd)) | (m_ovw & ~(vec_acc && m_vec == VW'(2)));
    nr = (conv_req & conv_busy) | (m_ovr & ~(vec_acc && m_vec == VW'(4)));
    p  = {nf, nr, no} & src_en;
    @(posedge clk);
    #1;
    m_flag = nf; m_unr = nu; m_ovw = no; m_ovr = nr;
    m_vec = enc(p);
    m_irq = glb_en & (|p);
    chk("R11 vec model", vec_out, m_vec);
    chk("R11 irq model", VW'(irq), VW'(m_irq));
    slot_wr = '0; slot_rd = '0; slot_clr = '0;
    conv_req = 1'b0; vec_acc = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset vec", vec_out, '0);
    chk("R1 reset irq", VW'(irq), '0);
    rst_n = 1'b1;
    src_en = '1; glb_en = 1'b1;
    tick();
    chk("R1 post-reset vec", vec_out, '0);
    // slot 3 written
    slot_wr[3] = 1'b1; tick();
    chk("R2 slot3 code", vec_out, VW'(12));
    chk("R3 irq on", VW'(irq), VW'(1));
    glb_en = 1'b0; tick();
    chk("R3 irq off glb", VW'(irq), VW'(0));
    chk("R3 vec unaffected", vec_out, VW'(12));
    glb_en = 1'b1;
    // rewrite unread slot 3
    slot_wr[3] = 1'b1; tick();
    chk("R4 overwrite code", vec_out, VW'(2));
    conv_req = 1'b1; conv_busy = 1'b1; tick();
    chk("R6 overwrite ranks above overrun", vec_out, VW'(2));
    vec_acc = 1'b1; tick();
    chk("R5 overrun code", vec_out, VW'(4));
    chk("R10 irq stays", VW'(irq), VW'(1));
    src_en[1] = 1'b0; tick();
    chk("R6 masked overrun", vec_out, VW'(12));
    vec_acc = 1'b1; tick();
    chk("R8 access keeps slot flag", vec_out, VW'(12));
    src_en[1] = 1'b1; tick();
    chk("R7 overrun survived access", vec_out, VW'(4));
    // set and clear on slot 3 at once, with read of old result
    slot_rd[3] = 1'b1; slot_wr[3] = 1'b1; vec_acc = 1'b1; tick();
    chk("R9 overrun cleared", vec_out, VW'(12));
    slot_clr[3] = 1'b1; tick();
    chk("R8 software clear", vec_out, VW'(0));
    chk("R3 irq idle", VW'(irq), VW'(0));
    slot_wr[0] = 1'b1; slot_wr[15] = 1'b1; tick();
    chk("R6 slot0 over slot15", vec_out, VW'(6));
    slot_rd[0] = 1'b1; tick();
    chk("R2 slot15 code", vec_out, VW'(36));
    // random phase
    for (int c = 0; c < 4000; c++) begin
      for (int b = 0; b < NS; b++) begin
        slot_wr[b]  = ($urandom % 10) == 0;
        slot_rd[b]  = ($urandom % 6) == 0;
        slot_clr[b] = ($urandom % 20) == 0;
      end
      conv_req  = ($urandom % 5) == 0;
      conv_busy = ($urandom % 2) == 0;
      vec_acc   = ($urandom % 3) == 0;
      if (($urandom % 50) == 0) src_en = NSRC'($urandom) | NSRC'(3);
      glb_en = ($urandom % 8) != 0;
      tick();
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial void'($urandom(32'h5eed_1234));
endmodule